// File: doc/BRIEF.md
# Key Event Queue with Destructive and Peek Reads

This block keeps a sixteen-slot ring of keypad events for a command decoder. Each event carries a seven-bit key code and a press/release flag. The block packs the two into one byte, with the flag in the top bit. It appends that byte behind the events already held. In the same cycle it raises a one-cycle pulse that the decoder uses to set its keypad interrupt status. If the ring is already full, the event is dropped and a one-cycle overflow pulse is raised instead. While the decoder reports that an overflow error is still pending, new events are discarded and no pulse of either kind is raised.

There are two read paths, and both are combinational on the current state. The destructive read first moves the head one slot forward and then returns the byte at the new head. As a result, the slot at the head always holds the byte that was returned last. The read gives zero, and changes nothing, while one entry or fewer is held. The peek read takes a byte index and returns the byte that many slots past the head, or zero when the index is not below the fill count. A peek never changes any state. A flush input, driven when the configuration is written, empties the ring.

Top module: `keyevt_fifo`

## Requirements
- R1: After reset the ring is empty: a peek at any index returns 0x00, a destructive read returns 0x00, and both pulse outputs are low.
- R2: An accepted event is stored as {press, code[6:0]}, with the press flag in bit 7, at slot (head + count) mod 16. The count then grows by one, and `kbd_irq_set` is high in the same cycle as `evt_valid`.
- R3: An event that arrives while 16 entries are held, after any same-cycle read has been applied, is dropped. `ovf_err` is high for that cycle, `kbd_irq_set` stays low and the stored contents are unchanged.
- R4: While `ovf_pending` is high, an event is ignored: both pulses stay low and the contents and count are unchanged.
- R5: A destructive read with a count of 0 or 1 returns 0x00 and leaves the head and count unchanged.
- R6: A destructive read with a count of 2 or more advances the head by one modulo 16 and lowers the count by one. In that same cycle `pop_data` shows the byte at the new head.
- R7: A peek with index i returns 0x00 when i is greater than or equal to the count. Otherwise it returns the byte at (head + i) mod 16. A peek changes no state.
- R8: A flush sets the head and count to zero. In the same cycle an event and a destructive read are both ignored: no pulses, and `pop_data` is 0x00.
- R9: When an event and a destructive read arrive in the same cycle, the read is applied first. A full ring therefore accepts the event without overflow, and the count stays unchanged.
- R10: Slot indexes wrap modulo 16, so the ring keeps its order across any number of passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A key event is offered this cycle |
| evt_code | input | 7 | Key code of the event |
| evt_press | input | 1 | Press (1) or release (0) flag |
| ovf_pending | input | 1 | Decoder holds an overflow error together with its error status bit |
| flush | input | 1 | Empty the ring (configuration write) |
| pop_req | input | 1 | Destructive read this cycle |
| pop_data | output | 8 | Byte returned by the destructive read |
| peek_idx | input | 8 | Byte index of the peek read |
| peek_data | output | 8 | Byte returned by the peek read |
| kbd_irq_set | output | 1 | One-cycle pulse: an event was stored |
| ovf_err | output | 1 | One-cycle pulse: an event was dropped because the ring was full |

## Verification
The bench fills the ring to all sixteen slots and offers one more event. A design that stored it anyway would overwrite the oldest entry, and that would show up in later peeks. It sends an event and a read together when the ring is full. A design that checked fullness before applying the read would raise a false overflow. Destructive reads are driven down to a count of one and then zero. A design that returned the head byte, or let the count go below one, would return stale data where 0x00 is expected. The bench also runs many passes around the ring, peeks at indexes at, beyond and far beyond the count, and raises flush together with events and reads. Each of these checks catches its own class of bug: pointer wrap errors, missing range checks and leaked pulses.

// File: rtl/keyevt_pkg.sv
package keyevt_pkg;
  localparam int CODE_W  = 7;
  localparam int ENTRY_W = CODE_W + 1;

  typedef logic [ENTRY_W-1:0] entry_t;

  function automatic entry_t pack_event(logic [CODE_W-1:0] code, logic press);
    return {press, code};
  endfunction
endpackage

// File: rtl/keyevt_store.sv
module keyevt_store #(
  parameter int DEPTH_LOG2 = 4,
  parameter int ENTRY_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [DEPTH_LOG2-1:0] waddr,
  input  logic [ENTRY_W-1:0]    wdata,
  input  logic [DEPTH_LOG2-1:0] raddr_a,
  output logic [ENTRY_W-1:0]    rdata_a,
  input  logic [DEPTH_LOG2-1:0] raddr_b,
  output logic [ENTRY_W-1:0]    rdata_b
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [DEPTH-1:0]   wsel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wsel[g] = we && (waddr == DEPTH_LOG2'(g));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (!rst_n)       slots[k] <= '0;
      else if (wsel[k]) slots[k] <= wdata;
    end
  end

  assign rdata_a = slots[raddr_a];
  assign rdata_b = slots[raddr_b];
endmodule

// File: rtl/keyevt_ctrl.sv
module keyevt_ctrl #(
  parameter int DEPTH_LOG2 = 4,
  parameter int IDX_W      = 8,
  localparam int LEN_W     = DEPTH_LOG2 + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evt_valid,
  input  logic                  ovf_pending,
  input  logic                  flush,
  input  logic                  pop_req,
  input  logic [IDX_W-1:0]      peek_idx,
  output logic                  push_ok,
  output logic                  ovf_hit,
  output logic                  pop_ok,
  output logic                  peek_hit,
  output logic [DEPTH_LOG2-1:0] wr_slot,
  output logic [DEPTH_LOG2-1:0] pop_slot,
  output logic [DEPTH_LOG2-1:0] peek_slot,
  output logic [DEPTH_LOG2-1:0] head_q,
  output logic [LEN_W-1:0]      count_q
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  function automatic logic [DEPTH_LOG2-1:0] ring_add(
    logic [DEPTH_LOG2-1:0] base, logic [DEPTH_LOG2-1:0] off);
    return base + off;
  endfunction

  function automatic logic below_count(logic [IDX_W-1:0] idx, logic [LEN_W-1:0] cnt);
    return ({{(IDX_W > LEN_W ? 1 : LEN_W - IDX_W + 1){1'b0}}, idx} <
            {{(IDX_W > LEN_W ? IDX_W - LEN_W + 1 : 1){1'b0}}, cnt});
  endfunction

  logic [DEPTH_LOG2-1:0] head_a;
  logic [LEN_W-1:0]      count_a;
  logic                  push_try;
  logic                  full_a;

  // Read is applied before the push of the same cycle (R9)
  assign pop_ok   = pop_req && !flush && (count_q > LEN_W'(1));
  assign head_a   = pop_ok ? ring_add(head_q, DEPTH_LOG2'(1)) : head_q;
  assign count_a  = pop_ok ? count_q - LEN_W'(1) : count_q;
  assign pop_slot = ring_add(head_q, DEPTH_LOG2'(1));

  assign push_try = evt_valid && !flush && !ovf_pending;
  assign full_a   = (count_a == LEN_W'(DEPTH));
  assign push_ok  = push_try && !full_a;
  assign ovf_hit  = push_try && full_a;
  assign wr_slot  = ring_add(head_a, count_a[DEPTH_LOG2-1:0]);

  assign peek_hit  = below_count(peek_idx, count_q);
  assign peek_slot = ring_add(head_q, peek_idx[DEPTH_LOG2-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_a;
      count_q <= count_a + LEN_W'(push_ok);
    end
  end
endmodule

// File: rtl/keyevt_fifo.sv
module keyevt_fifo #(
  parameter int DEPTH_LOG2 = 4,
  parameter int IDX_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        evt_valid,
  input  logic [keyevt_pkg::CODE_W-1:0]  evt_code,
  input  logic                        evt_press,
  input  logic                        ovf_pending,
  input  logic                        flush,
  input  logic                        pop_req,
  output logic [keyevt_pkg::ENTRY_W-1:0] pop_data,
  input  logic [IDX_W-1:0]            peek_idx,
  output logic [keyevt_pkg::ENTRY_W-1:0] peek_data,
  output logic                        kbd_irq_set,
  output logic                        ovf_err
);
  import keyevt_pkg::*;
  localparam int LEN_W = DEPTH_LOG2 + 1;

  logic                  push_ok, ovf_hit, pop_ok, peek_hit;
  logic [DEPTH_LOG2-1:0] wr_slot, pop_slot, peek_slot, head_q;
  logic [LEN_W-1:0]      count_q;
  entry_t                pop_raw, peek_raw;

  keyevt_ctrl #(.DEPTH_LOG2(DEPTH_LOG2), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .ovf_pending(ovf_pending),
    .flush(flush), .pop_req(pop_req), .peek_idx(peek_idx),
    .push_ok(push_ok), .ovf_hit(ovf_hit), .pop_ok(pop_ok), .peek_hit(peek_hit),
    .wr_slot(wr_slot), .pop_slot(pop_slot), .peek_slot(peek_slot),
    .head_q(head_q), .count_q(count_q)
  );

  keyevt_store #(.DEPTH_LOG2(DEPTH_LOG2), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push_ok), .waddr(wr_slot),
    .wdata(pack_event(evt_code, evt_press)),
    .raddr_a(pop_slot), .rdata_a(pop_raw),
    .raddr_b(peek_slot), .rdata_b(peek_raw)
  );

  assign pop_data    = pop_ok   ? pop_raw  : '0;
  assign peek_data   = peek_hit ? peek_raw : '0;
  assign kbd_irq_set = push_ok;
  assign ovf_err     = ovf_hit;
endmodule

// File: rtl/keyevt_chk.sv
module keyevt_chk #(
  parameter int DEPTH_LOG2 = 4,
  localparam int LEN_W     = DEPTH_LOG2 + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  evt_valid,
  input logic                  ovf_pending,
  input logic                  flush,
  input logic                  pop_req,
  input logic [7:0]            pop_data,
  input logic                  kbd_irq_set,
  input logic                  ovf_err,
  input logic                  pop_ok,
  input logic [DEPTH_LOG2-1:0] head_q,
  input logic [LEN_W-1:0]      count_q
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LEN_W'(DEPTH));

  p_no_store_on_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> !kbd_irq_set);

  p_pending_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pending |-> (!kbd_irq_set && !ovf_err));

  p_short_pop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count_q <= LEN_W'(1)) |-> (pop_data == 8'h00));

  p_short_pop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !flush && !evt_valid && count_q <= LEN_W'(1)) |=> $stable(count_q));

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !kbd_irq_set) |=> (count_q == $past(count_q) - LEN_W'(1)));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_q == '0 && head_q == '0));

  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!kbd_irq_set && !ovf_err && pop_data == 8'h00));

  p_full_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && evt_valid && !ovf_pending) |-> (kbd_irq_set && !ovf_err));
endmodule

bind keyevt_fifo keyevt_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .ovf_pending(ovf_pending),
  .flush(flush), .pop_req(pop_req), .pop_data(pop_data),
  .kbd_irq_set(kbd_irq_set), .ovf_err(ovf_err), .pop_ok(pop_ok),
  .head_q(head_q), .count_q(count_q)
);

// File: tb/sim_keyevt_fifo.sv
module sim_keyevt_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_valid = 1'b0;
  logic [6:0] evt_code = '0;
  logic       evt_press = 1'b0;
  logic       ovf_pending = 1'b0;
  logic       flush = 1'b0;
  logic       pop_req = 1'b0;
  logic [7:0] peek_idx = '0;
  logic [7:0] pop_data, peek_data;
  logic       kbd_irq_set, ovf_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int model_q[$];

  always #10 clk = ~clk;

  keyevt_fifo u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .evt_press(evt_press), .ovf_pending(ovf_pending), .flush(flush),
    .pop_req(pop_req), .pop_data(pop_data), .peek_idx(peek_idx),
    .peek_data(peek_data), .kbd_irq_set(kbd_irq_set), .ovf_err(ovf_err)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, compare against the queue model, then advance it
  task automatic cyc(bit v, int code, bit press, bit pend, bit fl, bit pop,
                     int idx, string tag);
    int e_pop, e_peek, sz;
    bit e_irq, e_ovf;
    @(negedge clk);
    evt_valid = v; evt_code = code[6:0]; evt_press = press;
    ovf_pending = pend; flush = fl; pop_req = pop; peek_idx = idx[7:0];
    #2;
    e_peek = (idx < model_q.size()) ? model_q[idx] : 0;
    e_pop  = (!fl && pop && model_q.size() > 1) ? model_q[1] : 0;
    sz     = model_q.size() - ((!fl && pop && model_q.size() > 1) ? 1 : 0);
    e_irq  = v && !fl && !pend && sz < 16;
    e_ovf  = v && !fl && !pend && sz >= 16;
    check(tag, "peek_data", peek_data, e_peek);
    check(tag, "pop_data", pop_data, e_pop);
    check(tag, "kbd_irq_set", kbd_irq_set, e_irq);
    check(tag, "ovf_err", ovf_err, e_ovf);
    @(posedge clk);
    if (fl) model_q.delete();
    else begin
      if (pop && model_q.size() > 1) void'(model_q.pop_front());
      if (e_irq) model_q.push_back(int'({press, code[6:0]}));
    end
  endtask

  task automatic peek_all(string tag);
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 0, 0, 0, i, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: empty after reset
    cyc(0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 1, 3, "R1");
    // R2: events packed and appended
    cyc(1, 7'h3c, 1, 0, 0, 0, 0, "R2");
    cyc(1, 7'h55, 0, 0, 0, 0, 0, "R2");
    cyc(1, 7'h01, 1, 0, 0, 0, 1, "R2");
    peek_all("R7");
    // R6 / R5: drain down to one entry, then short reads
    cyc(0, 0, 0, 0, 0, 1, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 1, "R6");
    cyc(0, 0, 0, 0, 0, 1, 0, "R5");
    cyc(0, 0, 0, 0, 0, 1, 0, "R5");
    peek_all("R5");
    // R3: fill, then overflow
    for (int k = 0; k < 15; k++) cyc(1, k + 16, k % 2, 0, 0, 0, k, "R2");
    cyc(1, 7'h7f, 1, 0, 0, 0, 15, "R3");
    cyc(1, 7'h70, 0, 0, 0, 0, 16, "R3");
    peek_all("R3");
    // R4: pending overflow error silences events, full or not
    cyc(1, 7'h11, 1, 1, 0, 0, 15, "R4");
    peek_all("R4");
    // R9: push and read together on a full ring
    cyc(1, 7'h22, 1, 0, 0, 1, 15, "R9");
    cyc(1, 7'h23, 0, 0, 0, 1, 14, "R9");
    peek_all("R9");
    cyc(0, 0, 0, 0, 0, 1, 0, "R6");
    cyc(1, 7'h12, 1, 1, 0, 0, 14, "R4");
    peek_all("R4");
    // R10: many passes around the ring
    for (int k = 0; k < 60; k++) begin
      cyc(1, (k * 5) % 128, k % 3 == 0, 0, 0, 0, k % 17, "R10");
      cyc(0, 0, 0, 0, 0, 1, (k * 7) % 16, "R10");
      cyc(1, (k * 11) % 128, 1, 0, 0, 1, k % 16, "R10");
      cyc(0, 0, 0, 0, 0, 1, 2, "R10");
    end
    peek_all("R10");
    // R7: far index
    cyc(0, 0, 0, 0, 0, 0, 200, "R7");
    cyc(0, 0, 0, 0, 0, 0, 255, "R7");
    // R8: flush with event and read together
    cyc(1, 7'h44, 1, 0, 1, 1, 0, "R8");
    peek_all("R8");
    cyc(1, 7'h45, 0, 0, 0, 0, 0, "R8");
    cyc(1, 7'h46, 1, 0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, 0, 1, 1, "R8");
    peek_all("R8");
    // R1: reset again mid-stream empties the ring
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); model_q.delete();
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 1, 0, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule